// File: doc/BRIEF.md
# Four-beat burst address sequencer

This block produces the address for each beat of a cache-line burst. A load strobe captures an external address. The low bits of that address are the starting offset within the line. The upper bits are held for the whole burst and pass unchanged to the output.

On each later clock edge where the active-low step input is low, a beat counter advances. The low output bits follow one of two orders, chosen by a static order input:
- **Interleaved:** the starting offset XOR the beat count.
- **Linear:** the starting offset plus the beat count, modulo the line length.

When the last beat has passed, the counter returns to zero, so the address returns to the starting offset.

A new load replaces the burst at once, even in mid-burst. The step input has no effect on a load edge.

Top module: `burst_seq`

## Requirements
- R1: After reset, `addr_out` is all zeros and `beat` is 0.
- R2: On a clock edge with `load` high, the whole of `addr_in` is captured. From the next cycle, `addr_out` equals that address and `beat` is 0, in either order mode.
- R3: On an edge with `load` high, `step_n` is ignored. A load with `step_n` low still yields `beat` 0 and the unmodified start offset.
- R4: With `order_ilv` low (linear), `addr_out[1:0]` equals (start offset + `beat`) mod 4. Examples: start 2 gives 2,3,0,1; start 3 gives 3,0,1,2.
- R5: With `order_ilv` high (interleaved), `addr_out[1:0]` equals start offset XOR `beat`. Examples: start 2 gives 2,3,0,1; start 1 gives 1,0,3,2.
- R6: On an edge with `load` low and `step_n` high, `beat` and `addr_out` hold their values.
- R7: On an edge with `load` low and `step_n` low, `beat` increments by one. After the fourth beat it wraps to 0, so `addr_out` returns to the loaded address.
- R8: `addr_out[ADDR_W-1:2]` equals the same bits of the last loaded address for the whole burst.
- R9: A load in mid-burst replaces the base address and restarts `beat` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `addr_in` and start a burst |
| step_n | input | 1 | Active-low advance to the next beat |
| order_ilv | input | 1 | Order select: 1 = interleaved, 0 = linear (static) |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | BEAT_W | Beat index within the burst |

## Verification
The bench builds the block with `ADDR_W` = 8 and `BEAT_W` = 2. This makes every starting offset and every beat of a four-beat line reachable in a short run.

For each of the four offsets and both orders, the bench loads with the step input held low, then walks the full burst with hold cycles inserted. It checks every address against the sum or XOR formula, confirms the wrap back to the start, and checks that the upper bits are preserved. It also reloads in mid-burst to confirm that the new base takes over and the beat count restarts.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step_n,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BEAT_W-1:0] beat
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_lin, low_ilv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (!step_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low_lin  = base_q[BEAT_W-1:0] + beat_q;
  assign low_ilv  = base_q[BEAT_W-1:0] ^ beat_q;
  assign addr_out = {base_q[ADDR_W-1 -: UP_W], order_ilv ? low_ilv : low_lin};
  assign beat     = beat_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              step_n,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [BEAT_W-1:0] beat
);
  logic [BEAT_W-1:0] lo;
  assign lo = addr_out[BEAT_W-1:0];

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat == '0) && (addr_out == $past(addr_in)));

  assert_load_ignores_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !step_n) |=> beat == '0);

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n && !order_ilv) |=> order_ilv || (lo == BEAT_W'($past(lo) + 1'b1)));

  assert_ilv_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && order_ilv) |=> !order_ilv || ((lo ^ beat) == $past(lo ^ beat)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> $stable(beat));

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n) |=> beat == BEAT_W'($past(beat) + 1'b1));

  assert_upper_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;
  localparam int AW = 8;
  localparam int BW = 2;

  logic clk = 0, rst_n = 0, load = 0, step_n = 1, order_ilv = 0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [BW-1:0] beat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_seq #(.ADDR_W(AW), .BEAT_W(BW)) u0 (.*);

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, int k, logic ilv);
    logic [BW-1:0] s, lo;
    s  = b[BW-1:0];
    lo = ilv ? (s ^ BW'(k)) : BW'(s + BW'(k));
    return {b[AW-1:BW], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] ea, int eb);
    checks++;
    if (addr_out !== ea || beat !== BW'(eb)) begin
      errors++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_out, beat, ea, eb);
    end
  endtask

  task automatic cyc(logic ld, logic sn, logic [AW-1:0] a);
    @(negedge clk);
    load = ld; step_n = sn; addr_in = a;
    @(posedge clk); #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(0, 1, '0); cyc(0, 1, '0);
    check("R1", '0, 0);
    @(negedge clk); rst_n = 1;
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] b;
        b = AW'((8'h5c ^ (m * 8'h30) ^ (s * 8'h44)) & 8'hfc) | AW'(s);
        @(negedge clk); order_ilv = m[0];
        cyc(1, 0, b);
        check("R2 R3", b, 0);
        for (int k = 1; k <= 4; k++) begin
          cyc(0, 1, 8'hff);
          check("R6", expect_addr(b, k - 1, m[0]), k - 1);
          cyc(0, 0, 8'hff);
          check(m ? "R5 R8" : "R4 R8", expect_addr(b, k % 4, m[0]), k % 4);
        end
        check("R7", b, 0);
      end
    end
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); order_ilv = m[0];
      cyc(1, 1, 8'ha1);
      cyc(0, 0, '0);
      cyc(0, 0, '0);
      check("R9 pre", expect_addr(8'ha1, 2, m[0]), 2);
      cyc(1, 0, 8'h3e);
      check("R9", 8'h3e, 0);
      cyc(0, 0, '0);
      check("R9 step", expect_addr(8'h3e, 1, m[0]), 1);
    end
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    check("R1 rerst", '0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule